// File: doc/BRIEF.md
# Dual-Channel Sample Delay Line

This block holds back two independent streams of complex baseband samples by a fixed count of sample periods. Samples reach it at a reduced rate, for instance 100 kHz after decimation, each marked by a one-clock valid strobe on a much faster fabric clock. Each lane owns a circular buffer in on-chip synchronous RAM. Writes on one lane can never land in the other lane's storage. At a 100 kHz sample rate, a 100 ms delay is 10,000 strobes. That fits a 32,768-word buffer (`ADDR_W = 15`, `DELAY = 10000`).

Each lane takes a 32-bit word: signed 16-bit I in bits 31:16 and signed 16-bit Q in bits 15:0. The word passes through bit-exact. On every input strobe the lane writes the new word and reads the word stored `DELAY` strobes earlier. The result appears one clock later together with an output strobe, so the single cycle of RAM read latency is matched by the strobe.

Until a lane has received `DELAY` samples since reset, its output word is zero and its primed flag is low. `DELAY` is a parameter separate from the buffer depth. Elaboration rejects a value outside 1 to 2^`ADDR_W`−1.

Top module: `dual_delay_line`

## Requirements
- R1: On the n-th input strobe of a lane (counting from 0 after reset), with n ≥ `DELAY`, the lane's output word equals, bit for bit, the word given on strobe n−`DELAY` of that same lane.
- R2: A lane's `out_valid` bit is high for exactly the one clock that follows each clock in which its `in_valid` bit is high, and is low otherwise.
- R3: For strobes n < `DELAY` the output word is zero and `out_primed` is low; from strobe n = `DELAY` on, `out_primed` is high and stays high until reset.
- R4: Strobes and data on one lane change neither the output word, the primed flag, the output strobe nor the fill progress of the other lane.
- R5: Between output strobes, a lane's output word and primed flag hold the value they took at its last output strobe.
- R6: The delay stays exact after the buffer pointer has wrapped, that is after more than 2^`ADDR_W` strobes.
- R7: While `rst_n` is low all outputs are zero. After reset is released, each lane restarts its fill from zero as in R3.
- R8: R1 and R3 hold at the delay extremes `DELAY` = 1 and `DELAY` = 2^`ADDR_W`−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_CH | Per-lane input sample strobe, one clock per sample |
| in_word | input | N_CH*WORD_W | Per-lane input words, lane c in bits [c*WORD_W +: WORD_W] |
| out_valid | output | N_CH | Per-lane output strobe, one clock after the input strobe |
| out_word | output | N_CH*WORD_W | Per-lane delayed words, same packing as `in_word` |
| out_primed | output | N_CH | Per-lane flag: the lane holds `DELAY` samples and its output is live |

## Verification
Every result of a lane is due on the clock edge that follows the edge capturing its input strobe. Both the RAM read data and the output strobe are registered once. The bench drives inputs on the falling edge and checks the strobed lanes' word, strobe and primed flag at the next falling edge, one clock after the strobe. At that same falling edge it checks that idle lanes hold their last values. Three instances with delays of 7, 1 and 31 over a 32-word buffer get the same stimulus, and each is compared against a history of the words driven.

// File: rtl/ddl_pkg.sv
package ddl_pkg;

  // Width of one signed component of the packed complex sample.
  localparam int IQ_W = 16;

  // Word layout: I component in the upper half, Q in the lower half.
  typedef struct packed {
    logic signed [IQ_W-1:0] i_part;
    logic signed [IQ_W-1:0] q_part;
  } iq_word_t;

  // A delay must leave at least one slot free and be non-zero.
  function automatic bit delay_ok(input int unsigned dly, input int unsigned aw);
    return (dly >= 1) && (dly <= ((32'd1 << aw) - 1));
  endfunction

  // Number of ring slots implied by an address width.
  function automatic int unsigned ring_depth(input int unsigned aw);
    return 32'd1 << aw;
  endfunction

endpackage

// File: rtl/ddl_ram.sv
module ddl_ram #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = ddl_pkg::ring_depth(ADDR_W);

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  // Registered read port: data is due one clock after the address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= store[rd_addr];
    end
  end

endmodule

// File: rtl/ddl_fill.sv
module ddl_fill #(
  parameter int CNT_W = 10,
  parameter int DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic full
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY);

  logic [CNT_W-1:0] seen;

  assign full = (seen == LIMIT);

  // Counts written samples and saturates once the delay is covered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (step && !full) begin
      seen <= seen + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ddl_lane.sv
module ddl_lane #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  parameter int DELAY  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_primed,
  output logic [ADDR_W-1:0] wr_ptr
);

  localparam logic [ADDR_W-1:0] DLY_A = ADDR_W'(DELAY);

  logic [ADDR_W-1:0] rd_ptr;
  logic [WORD_W-1:0] ram_q;
  logic              fill_full;
  logic              vld_q;
  logic              primed_q;

  // Address of the word written DELAY strobes ago, wrapping at the depth.
  function automatic logic [ADDR_W-1:0] look_back(input logic [ADDR_W-1:0] p);
    return p - DLY_A;
  endfunction

  assign rd_ptr = look_back(wr_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (in_valid) begin
      wr_ptr <= wr_ptr + ADDR_W'(1);
    end
  end

  ddl_ram #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (in_valid),
    .wr_addr(wr_ptr),
    .wr_data(in_word),
    .rd_en  (in_valid),
    .rd_addr(rd_ptr),
    .rd_data(ram_q)
  );

  ddl_fill #(
    .CNT_W(ADDR_W),
    .DELAY(DELAY)
  ) u_fill (
    .clk  (clk),
    .rst_n(rst_n),
    .step (in_valid),
    .full (fill_full)
  );

  // Strobe and primed flag take the same one-cycle path as the RAM read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        primed_q <= fill_full;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_primed = primed_q;
  assign out_word   = primed_q ? ram_q : '0;

endmodule

// File: rtl/dual_delay_line.sv
module dual_delay_line #(
  parameter int N_CH   = 2,
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  parameter int DELAY  = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          in_valid,
  input  logic [N_CH*WORD_W-1:0]   in_word,
  output logic [N_CH-1:0]          out_valid,
  output logic [N_CH*WORD_W-1:0]   out_word,
  output logic [N_CH-1:0]          out_primed
);

  // Per-lane write pointers, brought out for the checker.
  logic [N_CH-1:0][ADDR_W-1:0] lane_wptr;

  generate
    if (!ddl_pkg::delay_ok(DELAY, ADDR_W)) begin : g_bad_delay
      $error("dual_delay_line: DELAY must lie in 1 .. 2**ADDR_W-1");
    end
  endgenerate

  // One lane per channel, each with its own physical buffer.
  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_lane
      ddl_lane #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .DELAY (DELAY)
      ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid[c]),
        .in_word   (in_word[c*WORD_W +: WORD_W]),
        .out_valid (out_valid[c]),
        .out_word  (out_word[c*WORD_W +: WORD_W]),
        .out_primed(out_primed[c]),
        .wr_ptr    (lane_wptr[c])
      );
    end
  endgenerate

endmodule

module dual_delay_line_chk #(
  parameter int N_CH   = 2,
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_CH-1:0]             in_valid,
  input logic [N_CH-1:0]             out_valid,
  input logic [N_CH*WORD_W-1:0]      out_word,
  input logic [N_CH-1:0]             out_primed,
  input logic [N_CH-1:0][ADDR_W-1:0] lane_wptr
);

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_chk
      assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[c] |=> out_valid[c]);

      assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid[c] |=> !out_valid[c]);

      assert_primed_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_primed[c] |=> out_primed[c]);

      assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid[c] |-> ($stable(out_word[c*WORD_W +: WORD_W]) && $stable(out_primed[c])));

      assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[c] |=> (lane_wptr[c] == ADDR_W'($past(lane_wptr[c]) + ADDR_W'(1))));

      assert_lane_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid[c] |=> $stable(lane_wptr[c]));
    end
  endgenerate

endmodule

bind dual_delay_line dual_delay_line_chk #(
  .N_CH  (N_CH),
  .ADDR_W(ADDR_W),
  .WORD_W(WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_word  (out_word),
  .out_primed(out_primed),
  .lane_wptr (lane_wptr)
);

// File: tb/dual_delay_line_bench.sv
module dual_delay_line_bench;

  localparam int AW   = 5;
  localparam int W    = 32;
  localparam int NCH  = 2;
  localparam int DEP  = 1 << AW;
  localparam int D_A  = 7;
  localparam int D_B  = 1;
  localparam int D_C  = DEP - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]   vin = '0;
  logic [NCH*W-1:0] win = '0;

  logic [2:0][NCH-1:0]   ov;
  logic [2:0][NCH-1:0]   op;
  logic [2:0][NCH*W-1:0] ow;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dual_delay_line #(.N_CH(NCH), .ADDR_W(AW), .WORD_W(W), .DELAY(D_A)) u_dual_delay_line (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_word(win),
    .out_valid(ov[0]), .out_word(ow[0]), .out_primed(op[0]));

  dual_delay_line #(.N_CH(NCH), .ADDR_W(AW), .WORD_W(W), .DELAY(D_B)) u_dual_delay_line_dmin (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_word(win),
    .out_valid(ov[1]), .out_word(ow[1]), .out_primed(op[1]));

  dual_delay_line #(.N_CH(NCH), .ADDR_W(AW), .WORD_W(W), .DELAY(D_C)) u_dual_delay_line_dmax (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_word(win),
    .out_valid(ov[2]), .out_word(ow[2]), .out_primed(op[2]));

  // Reference model state
  logic [W-1:0] hist [NCH][0:1023];
  int           cnt  [NCH];
  int           pidx [NCH];
  logic [NCH-1:0] pend = '0;
  logic [W-1:0] hold_w [3][NCH];
  logic         hold_p [3][NCH];

  function automatic int dly_of(input int j);
    return (j == 0) ? D_A : ((j == 1) ? D_B : D_C);
  endfunction

  function automatic logic [W-1:0] gen(input int ch, input int n);
    logic [W-1:0] x;
    x = (32'(n) * 32'h9E3779B1) + (32'(ch) * 32'h7F4A7C15) + 32'h1357_2468;
    return x ^ (x >> 13);
  endfunction

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare all instances; strobed lanes against the model, idle lanes against held values.
  task automatic verify(input logic [NCH-1:0] mask, input string idle_tag);
    for (int j = 0; j < 3; j++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (mask[ch]) begin
          int d;
          int idx;
          logic [W-1:0] ew;
          string wtag;
          d   = dly_of(j);
          idx = pidx[ch];
          ew  = (idx >= d) ? hist[ch][idx-d] : '0;
          hold_w[j][ch] = ew;
          hold_p[j][ch] = (idx >= d);
          if (j != 0)        wtag = "R8";
          else if (idx < d)  wtag = "R3";
          else if (idx >= DEP) wtag = "R6";
          else               wtag = "R1";
          check("R2", "out_valid", 32'(ov[j][ch]), 32'd1);
          check(wtag, "out_word", ow[j][ch*W +: W], ew);
          check((j != 0) ? "R8" : "R3", "out_primed", 32'(op[j][ch]), 32'(hold_p[j][ch]));
        end else begin
          check("R2", "out_valid idle", 32'(ov[j][ch]), 32'd0);
          check(idle_tag, "out_word held", ow[j][ch*W +: W], hold_w[j][ch]);
          check(idle_tag, "out_primed held", 32'(op[j][ch]), 32'(hold_p[j][ch]));
        end
      end
    end
  endtask

  // One clock: check results of the previous strobe, then drive the next.
  task automatic step(input logic [NCH-1:0] mask, input string idle_tag);
    @(negedge clk);
    verify(pend, idle_tag);
    vin = mask;
    for (int ch = 0; ch < NCH; ch++) begin
      if (mask[ch]) begin
        logic [W-1:0] w;
        w = gen(ch, cnt[ch] + 7 * checks);
        win[ch*W +: W] = w;
        hist[ch][cnt[ch]] = w;
        pidx[ch] = cnt[ch];
        cnt[ch]++;
      end else begin
        win[ch*W +: W] = ~win[ch*W +: W];
      end
    end
    pend = mask;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vin   = '0;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      check("R7", "out_valid in reset", 32'(ov[j]), 32'd0);
      check("R7", "out_primed in reset", 32'(op[j]), 32'd0);
      check("R7", "lane0 word in reset", ow[j][W-1:0], '0);
      check("R7", "lane1 word in reset", ow[j][2*W-1:W], '0);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      cnt[ch]  = 0;
      pidx[ch] = 0;
      for (int j = 0; j < 3; j++) begin
        hold_w[j][ch] = '0;
        hold_p[j][ch] = 1'b0;
      end
    end
    pend  = '0;
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    step(2'b00, "R7");
  endtask

  task automatic t_gapped_fill();
    for (int i = 0; i < 40; i++) begin
      step(2'b11, "R5");
      for (int g = 0; g < (i % 3); g++) step(2'b00, "R5");
    end
    step(2'b00, "R5");
  endtask

  task automatic t_single_lane();
    for (int i = 0; i < 12; i++) step(2'b01, "R4");
    for (int i = 0; i < 5; i++)  step(2'b10, "R4");
    step(2'b00, "R4");
  endtask

  task automatic t_wrap_burst();
    for (int i = 0; i < 100; i++) step(2'b11, "R5");
    step(2'b00, "R5");
  endtask

  task automatic t_reset_restart();
    do_reset();
    for (int i = 0; i < 60; i++) begin
      step(2'((i % 4) == 3 ? 0 : (i % 4)), "R5");
      step(2'b11, "R5");
    end
    step(2'b00, "R5");
  endtask

  initial begin
    t_reset_state();
    t_gapped_fill();
    t_single_lane();
    t_wrap_burst();
    t_reset_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule